// File: doc/BRIEF.md
# Delay-Slot Next-PC and Branch Resolution Unit

This block chooses the fetch address for the following cycle in a 32-bit RISC pipeline that has one branch delay slot. The core presents one instruction per clock: its PC, its decoded fields and its two register operands. The unit classifies the instruction and evaluates any branch condition. It produces the successor PC, a taken flag and a return-address write for the register file. It also flags two kinds of illegal use.

A control instruction never redirects fetch straight away. In its own cycle the unit advances to the slot address, which is the PC plus 4, and it stores the decision and the target. In the next cycle, which holds the delay-slot instruction, it sends fetch either to the stored target or onward in sequence. The behaviour is a two-state machine. In `ST_SEQ`, normal flow, any control instruction takes the `CTL_SEEN` transition into `ST_SLOT`. `ST_SLOT` always leaves through `SLOT_DONE` back to `ST_SEQ`. A control instruction that arrives while in `ST_SLOT` is flagged and has no effect.

Top module: `npc_unit`

## Requirements
- R1: After reset the unit is in normal flow. A control instruction presented in the first cycle after reset is not reported as a slot violation, and it takes effect normally.
- R2: Opcode 000100 is taken when the rs operand equals the rt operand. Opcode 000101 is taken when the two operands differ.
- R3: Opcode 000110 is taken when rs, read as signed, is at most zero. Opcode 000111 is taken when rs is strictly positive.
- R4: Under opcode 000001 the rt field picks the test. 00000 tests rs < 0 and 00001 tests rs >= 0. 10000 and 10001 are the same two tests, each with a link. Any other rt value is not a control instruction.
- R5: In a control instruction's own cycle, `npc_o` is PC+4. `taken_o` shows the decision in that same cycle. The relative target is PC+4 plus the 16-bit offset, sign-extended and shifted left by two.
- R6: In the cycle after a control instruction, `npc_o` is the stored target if the branch was taken and PC+4 if it was not. It is never a target unless `taken_o` was high in the cycle before.
- R7: Opcodes 000010 and 000011 are always taken. Their target is bits 31..28 of PC+4, followed by the 26-bit index, followed by two zero bits.
- R8: Opcode 000000 with funct 001000, and with funct 001001, is always taken to the value of the rs operand.
- R9: Opcodes 000011, 000001/10000 and 000001/10001 write PC+8 to register 31, whether or not the branch is taken. Funct 001001 writes PC+8 to the register named by rd.
- R10: `link_fault_o` goes high for a linking compare-with-zero branch whose rs index is 31. It also goes high for funct 001001 when the rs index equals the rd index.
- R11: A control instruction in a delay slot raises `slot_fault_o`. It has no effect: it is not taken, it writes no link, the pending redirect is kept, and the next cycle is normal flow.
- R12: Any instruction that is not a control instruction gives `npc_o` = PC+4 with no taken flag and no link, and it opens no delay slot. This includes opcode 000000 with other funct values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | PC of the current instruction |
| opcode_i | input | 6 | Primary opcode field |
| rs_idx_i | input | 5 | rs register index |
| rt_idx_i | input | 5 | rt field (also selects the compare-with-zero test) |
| rd_idx_i | input | 5 | rd register index |
| funct_i | input | 6 | Function field for opcode 000000 |
| off_i | input | 16 | Branch offset in instruction words |
| idx_i | input | 26 | Jump index |
| rs_val_i | input | 32 | rs operand value |
| rt_val_i | input | 32 | rt operand value |
| npc_o | output | 32 | Fetch address for the next cycle |
| taken_o | output | 1 | The current control instruction will redirect |
| link_we_o | output | 1 | Return-address write enable |
| link_idx_o | output | 5 | Return-address destination register |
| link_val_o | output | 32 | Return address (PC+8) |
| slot_fault_o | output | 1 | Control instruction found in a delay slot |
| link_fault_o | output | 1 | Illegal register choice on a linking instruction |

## Verification
The bench watches the one-cycle redirect delay. A design that redirected in the branch's own cycle would skip the slot instruction. A design that redirected late would run one wrong-path instruction. Jumps are run across a 256 MB region boundary, with a PC whose slot address carries into bit 28. A design that formed the region from the branch PC and not from the slot PC would jump into the wrong region. The bench also covers signed zero comparisons at zero and at the most negative value, and untaken linking branches, which must still write the link register. Finally, it places a taken branch with a jump in its slot. A design that honoured the second jump, or dropped the first redirect, would leave the expected path.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;
    localparam int SEL_W = 5;

    localparam logic [OPC_W-1:0] OP_SPECIAL = 6'b000000;
    localparam logic [OPC_W-1:0] OP_ZCMP    = 6'b000001;
    localparam logic [OPC_W-1:0] OP_JMP     = 6'b000010;
    localparam logic [OPC_W-1:0] OP_JMPL    = 6'b000011;
    localparam logic [OPC_W-1:0] OP_BREQ    = 6'b000100;
    localparam logic [OPC_W-1:0] OP_BRNE    = 6'b000101;
    localparam logic [OPC_W-1:0] OP_BRLEZ   = 6'b000110;
    localparam logic [OPC_W-1:0] OP_BRGTZ   = 6'b000111;

    localparam logic [FN_W-1:0]  FN_RJMP    = 6'b001000;
    localparam logic [FN_W-1:0]  FN_RJMPL   = 6'b001001;

    localparam logic [SEL_W-1:0] ZS_LT      = 5'b00000;
    localparam logic [SEL_W-1:0] ZS_GE      = 5'b00001;
    localparam logic [SEL_W-1:0] ZS_LT_LNK  = 5'b10000;
    localparam logic [SEL_W-1:0] ZS_GE_LNK  = 5'b10001;

    typedef enum logic [2:0] {
        CK_NONE, CK_EQ, CK_NE, CK_LEZ, CK_GTZ, CK_LTZ, CK_GEZ, CK_ALWAYS
    } cond_kind_e;

    typedef enum logic [1:0] {
        TK_REL, TK_REGION, TK_REG
    } tgt_kind_e;

    typedef enum logic [1:0] {
        LK_NONE, LK_RA, LK_RD
    } link_kind_e;

    typedef struct packed {
        logic       is_ctl;
        cond_kind_e cond;
        tgt_kind_e  tgt;
        link_kind_e link;
    } ctl_dec_t;

    typedef enum logic {
        ST_SEQ, ST_SLOT
    } npc_state_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [FN_W-1:0]  funct_i,
    output ctl_dec_t         dec_o
);

    always_comb begin
        dec_o = '{is_ctl: 1'b0, cond: CK_NONE, tgt: TK_REL, link: LK_NONE};
        unique case (opcode_i)
            OP_BREQ:  dec_o = '{1'b1, CK_EQ,  TK_REL, LK_NONE};
            OP_BRNE:  dec_o = '{1'b1, CK_NE,  TK_REL, LK_NONE};
            OP_BRLEZ: dec_o = '{1'b1, CK_LEZ, TK_REL, LK_NONE};
            OP_BRGTZ: dec_o = '{1'b1, CK_GTZ, TK_REL, LK_NONE};
            OP_JMP:   dec_o = '{1'b1, CK_ALWAYS, TK_REGION, LK_NONE};
            OP_JMPL:  dec_o = '{1'b1, CK_ALWAYS, TK_REGION, LK_RA};
            OP_ZCMP: begin
                unique case (sel_i)
                    ZS_LT:     dec_o = '{1'b1, CK_LTZ, TK_REL, LK_NONE};
                    ZS_GE:     dec_o = '{1'b1, CK_GEZ, TK_REL, LK_NONE};
                    ZS_LT_LNK: dec_o = '{1'b1, CK_LTZ, TK_REL, LK_RA};
                    ZS_GE_LNK: dec_o = '{1'b1, CK_GEZ, TK_REL, LK_RA};
                    default:   ;
                endcase
            end
            OP_SPECIAL: begin
                unique case (funct_i)
                    FN_RJMP:  dec_o = '{1'b1, CK_ALWAYS, TK_REG, LK_NONE};
                    FN_RJMPL: dec_o = '{1'b1, CK_ALWAYS, TK_REG, LK_RD};
                    default:  ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cond_kind_e       cond_i,
    input  logic [XLEN-1:0]  a_i,
    input  logic [XLEN-1:0]  b_i,
    output logic             pass_o
);

    logic neg;
    logic zero;

    assign neg  = a_i[XLEN-1];
    assign zero = (a_i == '0);

    always_comb begin
        unique case (cond_i)
            CK_EQ:     pass_o = (a_i == b_i);
            CK_NE:     pass_o = (a_i != b_i);
            CK_LEZ:    pass_o = neg | zero;
            CK_GTZ:    pass_o = ~neg & ~zero;
            CK_LTZ:    pass_o = neg;
            CK_GEZ:    pass_o = ~neg;
            CK_ALWAYS: pass_o = 1'b1;
            default:   pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [XLEN-1:0]  reg_i,
    input  tgt_kind_e        kind_i,
    output logic [XLEN-1:0]  seq_o,
    output logic [XLEN-1:0]  ret_o,
    output logic [XLEN-1:0]  tgt_o
);

    localparam int EXT_W = XLEN - OFF_W - 2;
    localparam int REG_W = XLEN - IDX_W - 2;

    logic [XLEN-1:0] rel_disp;
    logic [XLEN-1:0] region_tgt;

    assign seq_o      = pc_i + XLEN'(4);
    assign ret_o      = pc_i + XLEN'(8);
    assign rel_disp   = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
    assign region_tgt = {seq_o[XLEN-1 -: REG_W], idx_i, 2'b00};

    always_comb begin
        unique case (kind_i)
            TK_REGION: tgt_o = region_tgt;
            TK_REG:    tgt_o = reg_i;
            default:   tgt_o = seq_o + rel_disp;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int OFF_W  = 16,
    parameter int IDX_W  = 26,
    parameter int RIDX_W = 5,
    parameter int RA_IDX = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [5:0]        opcode_i,
    input  logic [RIDX_W-1:0] rs_idx_i,
    input  logic [RIDX_W-1:0] rt_idx_i,
    input  logic [RIDX_W-1:0] rd_idx_i,
    input  logic [5:0]        funct_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [XLEN-1:0]   rs_val_i,
    input  logic [XLEN-1:0]   rt_val_i,
    output logic [XLEN-1:0]   npc_o,
    output logic              taken_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_idx_o,
    output logic [XLEN-1:0]   link_val_o,
    output logic              slot_fault_o,
    output logic              link_fault_o
);

    localparam logic [RIDX_W-1:0] RA = RIDX_W'(RA_IDX);

    ctl_dec_t        dec;
    logic            cond_pass;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] ret_pc;
    logic [XLEN-1:0] tgt_pc;

    npc_state_e      state_q, state_d;
    logic            pend_taken_q;
    logic [XLEN-1:0] pend_tgt_q;
    logic            act;

    npc_decode u_dec (
        .opcode_i (opcode_i),
        .sel_i    (rt_idx_i),
        .funct_i  (funct_i),
        .dec_o    (dec)
    );

    npc_cond #(.XLEN(XLEN)) u_cond (
        .cond_i (dec.cond),
        .a_i    (rs_val_i),
        .b_i    (rt_val_i),
        .pass_o (cond_pass)
    );

    npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
        .pc_i   (pc_i),
        .off_i  (off_i),
        .idx_i  (idx_i),
        .reg_i  (rs_val_i),
        .kind_i (dec.tgt),
        .seq_o  (seq_pc),
        .ret_o  (ret_pc),
        .tgt_o  (tgt_pc)
    );

    assign act = dec.is_ctl && (state_q == ST_SEQ);

    // transitions: CTL_SEEN (ST_SEQ -> ST_SLOT), SLOT_DONE (ST_SLOT -> ST_SEQ)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEQ:  if (dec.is_ctl) state_d = ST_SLOT;
            ST_SLOT: state_d = ST_SEQ;
            default: state_d = ST_SEQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_SEQ;
            pend_taken_q <= 1'b0;
            pend_tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (act) begin
                pend_taken_q <= cond_pass;
                pend_tgt_q   <= tgt_pc;
            end else begin
                pend_taken_q <= 1'b0;
            end
        end
    end

    always_comb begin
        npc_o        = seq_pc;
        taken_o      = 1'b0;
        link_we_o    = 1'b0;
        link_fault_o = 1'b0;
        slot_fault_o = 1'b0;
        link_idx_o   = (dec.link == LK_RD) ? rd_idx_i : RA;
        link_val_o   = ret_pc;
        unique case (state_q)
            ST_SEQ: begin
                taken_o      = dec.is_ctl && cond_pass;
                link_we_o    = dec.is_ctl && (dec.link != LK_NONE);
                link_fault_o = dec.is_ctl &&
                               (((dec.link == LK_RA) && (dec.tgt == TK_REL) && (rs_idx_i == RA)) ||
                                ((dec.link == LK_RD) && (rs_idx_i == rd_idx_i)));
            end
            ST_SLOT: begin
                npc_o        = pend_taken_q ? pend_tgt_q : seq_pc;
                slot_fault_o = dec.is_ctl;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5,
    parameter int RA_IDX = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   pc_i,
    input logic [5:0]        opcode_i,
    input logic [XLEN-1:0]   npc_o,
    input logic              taken_o,
    input logic              link_we_o,
    input logic [RIDX_W-1:0] link_idx_o,
    input logic [XLEN-1:0]   link_val_o,
    input logic              slot_fault_o,
    input logic              link_fault_o
);

    // R5
    taken_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> npc_o == pc_i + XLEN'(4));

    // R6
    no_stray_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(taken_o) |-> npc_o == pc_i + XLEN'(4));

    // R11
    slot_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_fault_o |-> (!taken_o && !link_we_o && !link_fault_o));

    // R11
    slot_no_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_fault_o |=> !slot_fault_o);

    // R11
    taken_no_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |=> !taken_o);

    // R9
    link_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> link_val_o == pc_i + XLEN'(8));

    // R9
    link_ra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we_o && opcode_i != 6'b000000) |-> link_idx_o == RIDX_W'(RA_IDX));

    // R10
    lfault_on_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_fault_o |-> link_we_o);

    // R12
    alu_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_i == 6'b001000) |-> (!taken_o && !link_we_o && !slot_fault_o));

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W), .RA_IDX(RA_IDX)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc_i         (pc_i),
    .opcode_i     (opcode_i),
    .npc_o        (npc_o),
    .taken_o      (taken_o),
    .link_we_o    (link_we_o),
    .link_idx_o   (link_idx_o),
    .link_val_o   (link_val_o),
    .slot_fault_o (slot_fault_o),
    .link_fault_o (link_fault_o)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc = '0;
    logic [5:0]  opc = '0;
    logic [4:0]  rs = '0, rt = '0, rd = '0;
    logic [5:0]  fn = '0;
    logic [15:0] off = '0;
    logic [25:0] idx = '0;
    logic [31:0] a = '0, b = '0;

    logic [31:0] npc;
    logic        taken, lwe, sfault, lfault;
    logic [4:0]  lidx;
    logic [31:0] lval;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    npc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pc_i(pc), .opcode_i(opc),
        .rs_idx_i(rs), .rt_idx_i(rt), .rd_idx_i(rd), .funct_i(fn),
        .off_i(off), .idx_i(idx), .rs_val_i(a), .rt_val_i(b),
        .npc_o(npc), .taken_o(taken), .link_we_o(lwe), .link_idx_o(lidx),
        .link_val_o(lval), .slot_fault_o(sfault), .link_fault_o(lfault)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", rq, act, exp);
        end
    endtask

    task automatic put(input logic [5:0] o, input logic [4:0] s, input logic [4:0] t,
                       input logic [4:0] d, input logic [5:0] f, input logic [15:0] of,
                       input logic [25:0] ix, input logic [31:0] va, input logic [31:0] vb,
                       input logic [31:0] p);
        @(negedge clk);
        opc = o; rs = s; rt = t; rd = d; fn = f; off = of; idx = ix; a = va; b = vb; pc = p;
        #1;
    endtask

    task automatic nop_at(input logic [31:0] p);
        put(6'b000000, 5'd0, 5'd0, 5'd0, 6'b000000, 16'h0, 26'h0, 32'h0, 32'h0, p);
    endtask

    function automatic logic [31:0] rel(input logic [31:0] p, input logic [15:0] o);
        return p + 32'd4 + {{14{o[15]}}, o, 2'b00};
    endfunction

    // relative branch followed by a nop in its slot
    task automatic run_br(input string rq, input logic [5:0] o, input logic [4:0] t,
                          input logic [31:0] va, input logic [31:0] vb, input logic [31:0] p,
                          input logic [15:0] of, input logic exp_tk, input logic exp_lk);
        put(o, 5'd3, t, 5'd0, 6'b000000, of, 26'h0, va, vb, p);
        chk({rq, " taken"}, {31'b0, taken}, {31'b0, exp_tk});
        chk({rq, " R5 branch-cycle npc"}, npc, p + 32'd4);
        chk({rq, " R9 link enable"}, {31'b0, lwe}, {31'b0, exp_lk});
        if (exp_lk) begin
            chk({rq, " R9 link index"}, {27'b0, lidx}, 32'd31);
            chk({rq, " R9 link value"}, lval, p + 32'd8);
        end
        nop_at(p + 32'd4);
        chk({rq, " R6 slot npc"}, npc, exp_tk ? rel(p, of) : p + 32'd8);
        chk({rq, " slot fault clear"}, {31'b0, sfault}, 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        opc = 6'b000010; idx = 26'h0000100; pc = 32'h100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 no slot fault after reset", {31'b0, sfault}, 32'd0);
        chk("R1 jump taken after reset", {31'b0, taken}, 32'd1);
        chk("R1 npc steps", npc, 32'h104);
        nop_at(32'h104);
        chk("R1 jump lands", npc, 32'h400);
        nop_at(32'h400);
        chk("R1 back to sequential", npc, 32'h404);
    endtask

    task automatic t_eq;
        run_br("R2 eq-match",    6'b000100, 5'd0, 32'd7, 32'd7, 32'h1000, 16'h0010, 1'b1, 1'b0);
        run_br("R2 eq-differ",   6'b000100, 5'd0, 32'd7, 32'd8, 32'h1000, 16'h0010, 1'b0, 1'b0);
        run_br("R2 ne-differ",   6'b000101, 5'd0, 32'd1, 32'd2, 32'h2000, 16'hFFF0, 1'b1, 1'b0);
        run_br("R2 ne-match",    6'b000101, 5'd0, 32'd5, 32'd5, 32'h2000, 16'hFFF0, 1'b0, 1'b0);
    endtask

    task automatic t_zero;
        run_br("R3 lez zero",    6'b000110, 5'd0, 32'h0,        32'h0, 32'h3000, 16'h0004, 1'b1, 1'b0);
        run_br("R3 lez minneg",  6'b000110, 5'd0, 32'h80000000, 32'h0, 32'h3000, 16'h0004, 1'b1, 1'b0);
        run_br("R3 lez one",     6'b000110, 5'd0, 32'h1,        32'h0, 32'h3000, 16'h0004, 1'b0, 1'b0);
        run_br("R3 gtz one",     6'b000111, 5'd0, 32'h1,        32'h0, 32'h3100, 16'h8000, 1'b1, 1'b0);
        run_br("R3 gtz zero",    6'b000111, 5'd0, 32'h0,        32'h0, 32'h3100, 16'h8000, 1'b0, 1'b0);
        run_br("R3 gtz minneg",  6'b000111, 5'd0, 32'h80000000, 32'h0, 32'h3100, 16'h8000, 1'b0, 1'b0);
    endtask

    task automatic t_zcmp;
        run_br("R4 ltz neg",      6'b000001, 5'b00000, 32'hFFFFFFFF, 32'h0, 32'h4000, 16'h0020, 1'b1, 1'b0);
        run_br("R4 gez zero",     6'b000001, 5'b00001, 32'h0,        32'h0, 32'h4000, 16'h0020, 1'b1, 1'b0);
        run_br("R4 gez neg",      6'b000001, 5'b00001, 32'hFFFFFFFB, 32'h0, 32'h4000, 16'h0020, 1'b0, 1'b0);
        run_br("R4 R9 ltzl pos",  6'b000001, 5'b10000, 32'd3,        32'h0, 32'h4100, 16'h0008, 1'b0, 1'b1);
        run_br("R4 R9 gezl pos",  6'b000001, 5'b10001, 32'd3,        32'h0, 32'h4200, 16'h0008, 1'b1, 1'b1);
        put(6'b000001, 5'd3, 5'b00010, 5'd0, 6'b000000, 16'h0020, 26'h0, 32'h0, 32'h0, 32'h4300);
        chk("R4 unknown sel not taken", {31'b0, taken}, 32'd0);
        chk("R4 unknown sel no link", {31'b0, lwe}, 32'd0);
        run_br("R4 no slot after unknown sel", 6'b000100, 5'd0, 32'd1, 32'd1, 32'h4304, 16'h0002, 1'b1, 1'b0);
    endtask

    task automatic t_jump;
        put(6'b000010, 5'd0, 5'd0, 5'd0, 6'b000000, 16'h0, 26'h3FFFFFF, 32'h0, 32'h0, 32'h1FFFFFFC);
        chk("R7 jump taken", {31'b0, taken}, 32'd1);
        chk("R7 jump no link", {31'b0, lwe}, 32'd0);
        nop_at(32'h20000000);
        chk("R7 region from slot pc", npc, 32'h2FFFFFFC);
        put(6'b000011, 5'd0, 5'd0, 5'd0, 6'b000000, 16'h0, 26'h0000010, 32'h0, 32'h0, 32'h50000000);
        chk("R9 jal link en", {31'b0, lwe}, 32'd1);
        chk("R9 jal link idx", {27'b0, lidx}, 32'd31);
        chk("R9 jal link val", lval, 32'h50000008);
        chk("R10 jal no fault", {31'b0, lfault}, 32'd0);
        nop_at(32'h50000004);
        chk("R7 jal target", npc, 32'h50000040);
    endtask

    task automatic t_regjump;
        put(6'b000000, 5'd4, 5'd0, 5'd0, 6'b001000, 16'h0, 26'h0, 32'hDEAD0000, 32'h0, 32'h300);
        chk("R8 jr taken", {31'b0, taken}, 32'd1);
        chk("R8 jr no link", {31'b0, lwe}, 32'd0);
        nop_at(32'h304);
        chk("R8 jr target", npc, 32'hDEAD0000);
        put(6'b000000, 5'd4, 5'd0, 5'd5, 6'b001001, 16'h0, 26'h0, 32'h00C0FFEC, 32'h0, 32'h600);
        chk("R9 jalr link idx rd", {27'b0, lidx}, 32'd5);
        chk("R9 jalr link val", lval, 32'h608);
        chk("R10 jalr distinct ok", {31'b0, lfault}, 32'd0);
        nop_at(32'h604);
        chk("R8 jalr target", npc, 32'h00C0FFEC);
        put(6'b000000, 5'd6, 5'd0, 5'd6, 6'b001001, 16'h0, 26'h0, 32'h700, 32'h0, 32'h640);
        chk("R10 jalr rs==rd fault", {31'b0, lfault}, 32'd1);
        nop_at(32'h644);
    endtask

    task automatic t_lfault;
        put(6'b000001, 5'd31, 5'b10001, 5'd0, 6'b000000, 16'h0004, 26'h0, 32'd1, 32'h0, 32'h900);
        chk("R10 gezl rs31 fault", {31'b0, lfault}, 32'd1);
        nop_at(32'h904);
        put(6'b000001, 5'd31, 5'b00001, 5'd0, 6'b000000, 16'h0004, 26'h0, 32'd1, 32'h0, 32'h980);
        chk("R10 gez rs31 no fault", {31'b0, lfault}, 32'd0);
        nop_at(32'h984);
        put(6'b000001, 5'd3, 5'b10000, 5'd0, 6'b000000, 16'h0004, 26'h0, 32'd1, 32'h0, 32'h9C0);
        chk("R10 ltzl rs3 no fault", {31'b0, lfault}, 32'd0);
        nop_at(32'h9C4);
    endtask

    task automatic t_slot;
        put(6'b000100, 5'd1, 5'd2, 5'd0, 6'b000000, 16'h0004, 26'h0, 32'd9, 32'd9, 32'h800);
        chk("R11 first branch taken", {31'b0, taken}, 32'd1);
        put(6'b000011, 5'd0, 5'd0, 5'd0, 6'b000000, 16'h0, 26'h0000FFF, 32'h0, 32'h0, 32'h804);
        chk("R11 slot fault raised", {31'b0, sfault}, 32'd1);
        chk("R11 slot jump not taken", {31'b0, taken}, 32'd0);
        chk("R11 slot jump no link", {31'b0, lwe}, 32'd0);
        chk("R11 first redirect kept", npc, 32'h814);
        nop_at(32'h814);
        chk("R11 normal after slot", npc, 32'h818);
        chk("R11 fault clears", {31'b0, sfault}, 32'd0);
        put(6'b000101, 5'd1, 5'd2, 5'd0, 6'b000000, 16'h0004, 26'h0, 32'd9, 32'd9, 32'hA00);
        put(6'b000010, 5'd0, 5'd0, 5'd0, 6'b000000, 16'h0, 26'h0000FFF, 32'h0, 32'h0, 32'hA04);
        chk("R11 fault after untaken", {31'b0, sfault}, 32'd1);
        chk("R11 untaken slot sequential", npc, 32'hA08);
        nop_at(32'hA08);
    endtask

    task automatic t_nonctl;
        put(6'b000000, 5'd1, 5'd2, 5'd3, 6'b100000, 16'h0, 26'h0, 32'd1, 32'd2, 32'hB00);
        chk("R12 special alu not taken", {31'b0, taken}, 32'd0);
        chk("R12 special alu no link", {31'b0, lwe}, 32'd0);
        chk("R12 special alu npc", npc, 32'hB04);
        put(6'b001000, 5'd1, 5'd2, 5'd0, 6'b000000, 16'h0004, 26'h0, 32'd1, 32'd2, 32'hB04);
        chk("R12 imm alu npc", npc, 32'hB08);
        put(6'b000010, 5'd0, 5'd0, 5'd0, 6'b000000, 16'h0, 26'h0000800, 32'h0, 32'h0, 32'hB08);
        chk("R12 no slot opened", {31'b0, sfault}, 32'd0);
        chk("R12 jump taken", {31'b0, taken}, 32'd1);
        nop_at(32'hB0C);
        chk("R12 jump lands", npc, 32'h2000);
    endtask

    initial begin
        t_reset();
        t_eq();
        t_zero();
        t_zcmp();
        t_jump();
        t_regjump();
        t_lfault();
        t_slot();
        t_nonctl();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule